// File: doc/BRIEF.md
# Word-Wide CRC-32 Slicing Engine

This block folds a 32-bit data word into a running CRC-32 on every cycle that the word is marked valid. The word is XORed with the held remainder and split into four bytes. Each byte addresses its own 256-entry remainder table, and the four table outputs are XORed to form the next remainder. The tables are computed at elaboration by constant functions. No memory file is loaded.

The engine uses the reflected CRC-32 form with polynomial 0xEDB88320. The remainder starts at all ones, and the value seen at the output is the bitwise inverse of the held remainder. A stream of bytes is packed into words with the first byte in the least significant byte. The result then equals a byte-serial CRC-32 engine fed the same bytes in that order. A start strobe seeds a new message. When start arrives together with a valid word, that word is the first word of the new message.

Top module: `crc32_word_slicer`

## Requirements
- R1: While reset is low, and in the first cycle after it is released, `crc_out` reads 0x00000000: the remainder holds all ones and the output is its inverse.
- R2: When `start` is high and `in_valid` is low, `crc_out` reads 0x00000000 after the next rising edge.
- R3: When both `start` and `in_valid` are low, `crc_out` keeps its value across the edge.
- R4: When `in_valid` is high and `start` is low, `crc_out` after the edge equals the inverse of the reflected CRC-32 (polynomial 0xEDB88320) of the previous remainder advanced over the four bytes of `in_word`. The bytes are taken least significant first, and each byte is shifted in least significant bit first.
- R5: When `start` and `in_valid` are both high, the word is folded into an all-ones seed and not into the held remainder.
- R6: Each byte lane uses its own table. A word with a single non-zero byte, at any lane position and with any of the 256 byte values, gives the same result as the byte-serial reference. Bits 7:0 hold the first byte, 15:8 the second, 23:16 the third and 31:24 the fourth.
- R7: A valid word (with `start` low) equal to the inverse of the current `crc_out` cancels the remainder to zero, so that `crc_out` reads 0xFFFFFFFF after the edge.
- R8: Folding in a word equal to the current `crc_out` appends the finalized CRC to the message least significant byte first. After that edge, `crc_out` reads the fixed residue 0x2144DF1C.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Seed a new message with an all-ones remainder |
| in_valid | input | 1 | Fold `in_word` into the remainder this cycle |
| in_word | input | 32 | Four message bytes, the first byte in bits 7:0 |
| crc_out | output | 32 | Inverted remainder, i.e. the finalized CRC so far |

## Verification
The hardest case to reach from the ports is each of the 1024 table entries. The path to an entry goes through the XOR with the held remainder, which the bench cannot set directly. The bench therefore asserts `start` with every word. The remainder is then the known all-ones seed, so the bench can compute the single-lane word that reaches each table index. It sweeps every byte value through every lane this way. The cancellation and residue cases need the word to depend on the current output. The bench reads `crc_out` and feeds back either its inverse or the value itself.

// File: rtl/crc_slice_pkg.sv
package crc_slice_pkg;

  localparam int CRC_W = 32;
  localparam int TBL_DEPTH = 256;

  typedef logic [TBL_DEPTH-1:0][CRC_W-1:0] remTable_t;

  typedef struct packed {
    logic seed;     // reload the remainder with all ones
    logic advance;  // fold the presented word this cycle
  } crcStrobe_t;

  // One reflected bit step of the long division.
  function automatic logic [CRC_W-1:0] bitStep(input logic [CRC_W-1:0] rem,
                                               input logic [CRC_W-1:0] poly);
    return rem[0] ? ((rem >> 1) ^ poly) : (rem >> 1);
  endfunction

  // Remainder table for a byte that still has 'hops' further bytes to travel.
  // hops = 0 is the single-byte table; each hop pushes the byte 8 places on.
  function automatic remTable_t buildTable(input logic [CRC_W-1:0] poly,
                                           input int hops);
    remTable_t baseTbl;
    remTable_t curTbl;
    logic [CRC_W-1:0] r;
    for (int i = 0; i < TBL_DEPTH; i++) begin
      r = CRC_W'(i);
      for (int b = 0; b < 8; b++) r = bitStep(r, poly);
      baseTbl[i] = r;
    end
    curTbl = baseTbl;
    for (int h = 0; h < hops; h++) begin
      for (int i = 0; i < TBL_DEPTH; i++) begin
        curTbl[i] = (curTbl[i] >> 8) ^ baseTbl[curTbl[i][7:0]];
      end
    end
    return curTbl;
  endfunction

endpackage

// File: rtl/crc_lane_table.sv
module crc_lane_table
  import crc_slice_pkg::*;
#(
  parameter logic [CRC_W-1:0] POLY = 32'hEDB88320,
  parameter int HOPS = 0
) (
  input  logic [7:0]       laneIdx,
  output logic [CRC_W-1:0] laneRem
);

  localparam remTable_t TBL = buildTable(POLY, HOPS);

  assign laneRem = TBL[laneIdx];

endmodule

// File: rtl/crc_slice_ctrl.sv
module crc_slice_ctrl
  import crc_slice_pkg::*;
(
  input  logic       start,
  input  logic       inValid,
  output crcStrobe_t strobe
);

  // start alone reseeds; start with a word folds the word into the seed.
  always_comb begin
    strobe.seed    = start;
    strobe.advance = inValid;
  end

endmodule

// File: rtl/crc_slice_datapath.sv
module crc_slice_datapath
  import crc_slice_pkg::*;
#(
  parameter logic [CRC_W-1:0] POLY = 32'hEDB88320,
  parameter int LANES = 4
) (
  input  logic               clk,
  input  logic               rst_n,
  input  crcStrobe_t         strobe,
  input  logic [LANES*8-1:0] inWord,
  output logic [CRC_W-1:0]   crcFinal
);

  localparam int WORD_W = LANES * 8;
  localparam logic [CRC_W-1:0] SEED = '1;

  logic [CRC_W-1:0] crcState;
  logic [CRC_W-1:0] crcBase;
  logic [WORD_W-1:0] mixWord;
  logic [CRC_W-1:0] laneRem [LANES];
  logic [CRC_W-1:0] crcNext;

  assign crcBase = strobe.seed ? SEED : crcState;
  assign mixWord = inWord ^ WORD_W'(crcBase);

  // Lane 0 is the first byte on the wire, so it travels furthest.
  for (genvar g = 0; g < LANES; g++) begin : g_lane
    crc_lane_table #(
      .POLY(POLY),
      .HOPS(LANES - 1 - g)
    ) u_tbl (
      .laneIdx(mixWord[8*g +: 8]),
      .laneRem(laneRem[g])
    );
  end

  always_comb begin
    crcNext = '0;
    for (int k = 0; k < LANES; k++) crcNext ^= laneRem[k];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      crcState <= SEED;
    end else if (strobe.advance) begin
      crcState <= crcNext;
    end else if (strobe.seed) begin
      crcState <= SEED;
    end
  end

  assign crcFinal = ~crcState;

endmodule

// File: rtl/crc32_word_slicer.sv
module crc32_word_slicer
  import crc_slice_pkg::*;
#(
  parameter logic [31:0] POLY = 32'hEDB88320
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        start,
  input  logic        in_valid,
  input  logic [31:0] in_word,
  output logic [31:0] crc_out
);

  crcStrobe_t strobe;

  crc_slice_ctrl u_ctrl (
    .start  (start),
    .inValid(in_valid),
    .strobe (strobe)
  );

  crc_slice_datapath #(
    .POLY (POLY),
    .LANES(4)
  ) u_dp (
    .clk     (clk),
    .rst_n   (rst_n),
    .strobe  (strobe),
    .inWord  (in_word),
    .crcFinal(crc_out)
  );

endmodule

// File: rtl/crc32_word_slicer_chk.sv
module crc32_word_slicer_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        start,
  input logic        in_valid,
  input logic [31:0] in_word,
  input logic [31:0] crc_out
);

  a_r1_reset_clear: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rst_n) |-> crc_out == 32'h0);

  a_r2_seed_only: assert property (@(posedge clk) disable iff (!rst_n)
    (start && !in_valid) |=> crc_out == 32'h0);

  a_r3_idle_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (!start && !in_valid) |=> $stable(crc_out));

  a_r5_seed_cancel: assert property (@(posedge clk) disable iff (!rst_n)
    (start && in_valid && in_word == 32'hFFFFFFFF) |=> crc_out == 32'hFFFFFFFF);

  a_r7_word_cancel: assert property (@(posedge clk) disable iff (!rst_n)
    (!start && in_valid && in_word == ~crc_out) |=> crc_out == 32'hFFFFFFFF);

  a_r8_residue: assert property (@(posedge clk) disable iff (!rst_n)
    (!start && in_valid && in_word == crc_out) |=> crc_out == 32'h2144DF1C);

endmodule

bind crc32_word_slicer crc32_word_slicer_chk u_chk (.*);

// File: tb/crc32_word_slicer_tb.sv
`timescale 1ns/1ps
module crc32_word_slicer_tb;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic start = 1'b0;
  logic in_valid = 1'b0;
  logic [31:0] in_word = '0;
  logic [31:0] crc_out;

  int total = 0;
  int bad = 0;
  logic [31:0] model = 32'hFFFFFFFF;
  logic done = 1'b0;

  always #2.5 clk = ~clk;

  crc32_word_slicer u_dut (
    .clk(clk), .rst_n(rst_n), .start(start),
    .in_valid(in_valid), .in_word(in_word), .crc_out(crc_out)
  );

  // Byte-serial, bit-at-a-time reference: bytes LSB first.
  function automatic logic [31:0] refWord(input logic [31:0] s, input logic [31:0] w);
    logic [31:0] r = s;
    for (int b = 0; b < 4; b++) begin
      r ^= {24'h0, w[8*b +: 8]};
      for (int j = 0; j < 8; j++) r = r[0] ? ((r >> 1) ^ 32'hEDB88320) : (r >> 1);
    end
    return r;
  endfunction

  task automatic check(input string req, input logic [31:0] exp);
    total++;
    if (crc_out !== exp) begin
      bad++;
      $display("FAIL %s actual=%08h expected=%08h", req, crc_out, exp);
    end
  endtask

  // Called at a falling edge; returns at the next falling edge.
  task automatic step(input logic st, input logic v, input logic [31:0] w);
    start = st; in_valid = v; in_word = w;
    if (v) model = refWord(st ? 32'hFFFFFFFF : model, w);
    else if (st) model = 32'hFFFFFFFF;
    @(negedge clk);
    start = 1'b0; in_valid = 1'b0; in_word = '0;
  endtask

  initial begin
    #(5.0 * 150000);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    logic [31:0] snap;
    repeat (3) @(negedge clk);
    check("R1", 32'h0);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1", 32'h0);

    // R6: every byte value through every lane, from the seed
    for (int lane = 0; lane < 4; lane++) begin
      for (int v = 0; v < 256; v++) begin
        step(1'b1, 1'b1, 32'(v) << (8 * lane));
        check("R6", ~model);
      end
    end

    // R4: multi-word messages
    for (int m = 0; m < 3; m++) begin
      step(1'b1, 1'b0, '0);
      check("R2", 32'h0);
      for (int i = 0; i < 6; i++) begin
        step(1'b0, 1'b1, 32'(i + 1) * 32'h9E3779B9 + 32'(m) * 32'h01234567);
        check("R4", ~model);
      end
    end

    // R4: ASCII "12345678" packed first byte in bits 7:0
    step(1'b1, 1'b0, '0);
    step(1'b0, 1'b1, 32'h34333231);
    check("R4", ~model);
    step(1'b0, 1'b1, 32'h38373635);
    check("R4", ~model);

    // R3: idle cycles hold the output
    snap = crc_out;
    for (int i = 0; i < 3; i++) begin
      step(1'b0, 1'b0, 32'hDEADBEEF);
      check("R3", snap);
    end

    // R5: start with a word mid-message restarts from the seed
    step(1'b0, 1'b1, 32'hA5A5A5A5);
    step(1'b1, 1'b1, 32'h0BADF00D);
    check("R5", ~refWord(32'hFFFFFFFF, 32'h0BADF00D));

    // R8: appending the finalized CRC gives the fixed residue
    step(1'b0, 1'b1, 32'h11223344);
    step(1'b0, 1'b1, crc_out);
    check("R8", 32'h2144DF1C);

    // R7: feeding back the inverted output cancels the remainder
    step(1'b1, 1'b1, 32'hCAFEBABE);
    step(1'b0, 1'b1, ~crc_out);
    check("R7", 32'hFFFFFFFF);

    // R2: seed-only after data
    step(1'b1, 1'b0, '0);
    check("R2", 32'h0);

    done = 1'b1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule